// File: doc/BRIEF.md
# Asynchronous Page Read Controller

This block sits between an asynchronous read bus and a word-wide memory array. It holds one four-word page in an internal buffer. A read to a page that is not in the buffer is a miss. A miss fetches the whole page from the array with a long access delay. Reads that stay inside the buffered page are hits. A hit is served from the buffer after a short delay. The page address is captured only while the latch strobe is high. The two word-select bits are not gated by the strobe: changing them at any time starts a new buffered read.

A timer counts internal clock cycles without bus activity. When the idle limit is reached, the block raises a standby indication. The last word stays on the data output during standby. The block works only while chip enable is high and bit 15 of the configuration word selects asynchronous operation. Dropping either one discards the buffered page. All latencies are parameters counted in clock cycles.

Top module: `async_page_reader`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rd_ready` and `standby` are 0 and `rd_data` is 0.
- R2: The word address is {`page_addr`, `word_sel`}, so one page is four consecutive words. `page_addr` is taken only in a cycle with `lat_en` high. Otherwise the last captured page is used.
- R3: An access is accepted at a clock edge when the block is enabled and either `lat_en` is high or `word_sel` differs from the last accepted selection. If the page is not buffered, `rd_ready` goes low at that edge. Exactly MISS_LAT edges later, `rd_ready` is 1 and the output holds the selected word.
- R4: An accepted access to the buffered page drops `rd_ready` at the accepting edge. HIT_LAT edges later, `rd_ready` returns with the selected word.
- R5: A change of `word_sel` with `lat_en` low is an access to the current page. It is served as a hit when that page is buffered.
- R6: Capturing a different page address makes the next access a miss. Re-capturing the buffered page address is a hit.
- R7: Whenever `ce` is 0 or `cfg_word[15]` is 0, the block is disabled. The buffered page is discarded, any pending read is cancelled, `rd_ready` is 0 and no access is accepted. The next enabled access is a miss.
- R8: After IDLE_CYC consecutive edges with no accepted access and no pending read, `standby` is 1. The held data word is unchanged.
- R9: An accepted access clears `standby` at the accepting edge. Its latency is the same as without standby.
- R10: `wait_o` equals `cfg_word[15]`, so it stays asserted for as long as asynchronous operation is selected.
- R11: `rd_data` shows the held word while `oe` is 1 and is 0 while `oe` is 0. `oe` does not affect `rd_ready` or accesses.
- R12: The array word at address a is ((a * 0x9E37) xor 0x5A5A), truncated to 16 bits.
- R13: An access with a new page during a fetch restarts the fetch, and its MISS_LAT delay counts from the restart. A `word_sel` change during a fetch of the same page joins that fetch, which then delivers the newly selected word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 16 | Configuration word; bit 15 = 1 selects asynchronous operation |
| ce | input | 1 | Chip enable, active high |
| oe | input | 1 | Output enable, active high |
| lat_en | input | 1 | Latch strobe for the page address |
| page_addr | input | 6 | Page address (upper word-address bits) |
| word_sel | input | 2 | Word within the page, not gated by the latch strobe |
| rd_data | output | 16 | Read data |
| rd_ready | output | 1 | Read data valid |
| standby | output | 1 | Automatic standby indication |
| wait_o | output | 1 | Wait indication, asserted in asynchronous mode |

## Verification
The bench builds the block with MISS_LAT = 6, HIT_LAT = 2 and IDLE_CYC = 15, which is 150 ns at the 100 MHz bench clock. With these values, a fetch is long enough that a new page or a new word selection can arrive while it is still in flight. This brings both the restart and join cases of R13 within reach. A hit of two cycles is long enough to see `rd_ready` low before the buffered word returns. The 15-cycle idle limit lets standby entry and exit happen many times within a short run, including exits straight into a hit or a miss.

// File: rtl/apr_pkg.sv
package apr_pkg;

    localparam int unsigned DATA_W    = 16;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned PAGE_WRDS = 4;
    localparam int unsigned SEL_W     = $clog2(PAGE_WRDS);
    localparam int unsigned PAGE_W    = ADDR_W - SEL_W;
    localparam int unsigned CFG_W     = 16;
    localparam int unsigned ASYNC_BIT = 15;

    typedef logic [DATA_W-1:0]                 word_t;
    typedef logic [PAGE_W-1:0]                 page_t;
    typedef logic [SEL_W-1:0]                  sel_t;
    typedef logic [PAGE_WRDS-1:0][DATA_W-1:0]  line_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_HIT,
        ACC_JOIN,
        ACC_MISS
    } acc_kind_e;

    typedef struct packed {
        logic  valid;
        page_t page;
        sel_t  sel;
    } acc_req_t;

    function automatic word_t array_word(input logic [ADDR_W-1:0] a);
        logic [31:0] prod;
        prod = 32'(a) * 32'h0000_9E37;
        return prod[DATA_W-1:0] ^ word_t'(16'h5A5A);
    endfunction

    function automatic line_t build_line(input page_t pg);
        line_t l;
        for (int k = 0; k < PAGE_WRDS; k++) begin
            l[k] = array_word({pg, sel_t'(k)});
        end
        return l;
    endfunction

    function automatic word_t pick_word(input line_t l, input sel_t s);
        return l[s];
    endfunction

endpackage

// File: rtl/apr_array.sv
module apr_array
    import apr_pkg::*;
#(
    parameter int unsigned MISS_LAT = 6
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  abort,
    input  logic  req,
    input  page_t req_page,
    output logic  busy,
    output logic  done,
    output line_t line
);
    localparam int unsigned CW = $clog2(MISS_LAT + 1);

    logic [CW-1:0] cnt;
    page_t         page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            page_q <= '0;
        end else if (abort) begin
            cnt    <= '0;
        end else if (req) begin
            cnt    <= CW'(MISS_LAT);
            page_q <= req_page;
        end else if (cnt != '0) begin
            cnt    <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));
    assign line = build_line(page_q);

endmodule

// File: rtl/apr_page_buf.sv
module apr_page_buf
    import apr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  start,
    input  page_t start_tag,
    input  logic  fill,
    input  line_t fill_line,
    output logic  valid,
    output page_t tag,
    output line_t line
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            tag   <= '0;
            line  <= '0;
        end else if (clear) begin
            valid <= 1'b0;
        end else if (start) begin
            valid <= 1'b0;
            tag   <= start_tag;
        end else if (fill) begin
            valid <= 1'b1;
            line  <= fill_line;
        end
    end

endmodule

// File: rtl/apr_idle_timer.sv
module apr_idle_timer #(
    parameter int unsigned IDLE_CYC = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic activity,
    output logic standby
);
    localparam int unsigned IW = $clog2(IDLE_CYC + 1);

    logic [IW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || activity) begin
            cnt <= '0;
        end else if (cnt != IW'(IDLE_CYC)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign standby = (cnt == IW'(IDLE_CYC));

    a_r9_activity_wakes: assert property (@(posedge clk) disable iff (rst)
        activity |=> !standby);

endmodule

// File: rtl/async_page_reader.sv
module async_page_reader
    import apr_pkg::*;
#(
    parameter int unsigned MISS_LAT = 6,
    parameter int unsigned HIT_LAT  = 2,
    parameter int unsigned IDLE_CYC = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              ce,
    input  logic              oe,
    input  logic              lat_en,
    input  logic [PAGE_W-1:0] page_addr,
    input  logic [SEL_W-1:0]  word_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ready,
    output logic              standby,
    output logic              wait_o
);
    localparam int unsigned HW = $clog2(HIT_LAT + 1);

    logic          active;
    acc_req_t      req;
    acc_kind_e     kind;
    sel_t          sel_q;
    page_t         cur_page;
    logic [HW-1:0] hit_cnt;
    word_t         data_q;
    logic          ready_q;

    logic          arr_busy, arr_done;
    line_t         arr_line;
    logic          buf_valid;
    page_t         buf_tag;
    line_t         buf_line;
    logic          activity;

    assign active    = ce && cfg_word[ASYNC_BIT];
    assign req.valid = active && (lat_en || (word_sel != sel_q));
    assign req.page  = lat_en ? page_addr : cur_page;
    assign req.sel   = word_sel;

    always_comb begin
        if (!req.valid)
            kind = ACC_NONE;
        else if (buf_valid && (buf_tag == req.page))
            kind = ACC_HIT;
        else if (arr_busy && (buf_tag == req.page))
            kind = ACC_JOIN;
        else
            kind = ACC_MISS;
    end

    apr_array #(.MISS_LAT(MISS_LAT)) u_array (
        .clk      (clk),
        .rst      (rst),
        .abort    (!active),
        .req      (kind == ACC_MISS),
        .req_page (req.page),
        .busy     (arr_busy),
        .done     (arr_done),
        .line     (arr_line)
    );

    apr_page_buf u_buf (
        .clk       (clk),
        .rst       (rst),
        .clear     (!active),
        .start     (kind == ACC_MISS),
        .start_tag (req.page),
        .fill      (arr_done),
        .fill_line (arr_line),
        .valid     (buf_valid),
        .tag       (buf_tag),
        .line      (buf_line)
    );

    assign activity = req.valid || (hit_cnt != '0) || arr_busy;

    apr_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .activity (activity),
        .standby  (standby)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_cnt  <= '0;
            ready_q  <= 1'b0;
            data_q   <= '0;
            sel_q    <= '0;
            cur_page <= '0;
        end else if (!active) begin
            hit_cnt  <= '0;
            ready_q  <= 1'b0;
        end else begin
            unique case (kind)
                ACC_MISS: begin
                    hit_cnt <= '0;
                    ready_q <= 1'b0;
                end
                ACC_HIT: begin
                    hit_cnt <= HW'(HIT_LAT);
                    ready_q <= 1'b0;
                end
                default: begin
                    if (arr_done) begin
                        data_q  <= pick_word(arr_line, req.sel);
                        ready_q <= 1'b1;
                    end
                    if (hit_cnt == HW'(1)) begin
                        data_q  <= pick_word(buf_line, req.sel);
                        ready_q <= 1'b1;
                    end
                    if (hit_cnt != '0) hit_cnt <= hit_cnt - 1'b1;
                end
            endcase
            if (req.valid) sel_q <= req.sel;
            if (req.valid && lat_en) cur_page <= page_addr;
        end
    end

    assign rd_data  = oe ? data_q : '0;
    assign rd_ready = ready_q;
    assign wait_o   = cfg_word[ASYNC_BIT];

    a_r3_ready_needs_page: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> buf_valid);

    a_r4_hit_wait_not_ready: assert property (@(posedge clk) disable iff (rst)
        (hit_cnt > HW'(1)) |=> !rd_ready);

    a_r5_sel_change_keeps_page: assert property (@(posedge clk) disable iff (rst)
        (active && buf_valid && !lat_en) |=> buf_valid);

    a_r7_disable_flushes: assert property (@(posedge clk) disable iff (rst)
        !active |=> (!buf_valid && !arr_busy && !rd_ready));

    a_r13_join_keeps_fetch: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_JOIN && !arr_done) |=> arr_busy);

endmodule

// File: tb/async_page_reader_bench.sv
module async_page_reader_bench;
    localparam int MISS = 6;
    localparam int HIT  = 2;
    localparam int IDLE = 15;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cfg_word;
    logic        ce, oe, lat_en;
    logic [5:0]  page_addr;
    logic [1:0]  word_sel;
    logic [15:0] rd_data;
    logic        rd_ready, standby, wait_o;

    always #5 clk = ~clk;

    async_page_reader #(.MISS_LAT(MISS), .HIT_LAT(HIT), .IDLE_CYC(IDLE)) u_async_page_reader (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .ce(ce), .oe(oe),
        .lat_en(lat_en), .page_addr(page_addr), .word_sel(word_sel),
        .rd_data(rd_data), .rd_ready(rd_ready), .standby(standby), .wait_o(wait_o)
    );

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R1";
    bit    done_flag = 0;

    // reference model state
    int m_valid, m_tag, m_miss, m_hit, m_lo, m_cur, m_ready, m_data, m_idle;
    int m_buf [4];

    function automatic int ref_word(int a);
        return ((a * 40503) ^ 23130) & 16'hFFFF;
    endfunction

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", phase, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int act, evt, busy, rp;
        if (rst) begin
            m_valid = 0; m_tag = 0; m_miss = 0; m_hit = 0; m_lo = 0; m_cur = 0;
            m_ready = 0; m_data = 0; m_idle = 0;
            for (int k = 0; k < 4; k++) m_buf[k] = 0;
        end else begin
            act  = (ce && cfg_word[15]) ? 1 : 0;
            busy = (m_miss > 0 || m_hit > 0) ? 1 : 0;
            evt  = (act != 0 && (lat_en || int'(word_sel) != m_lo)) ? 1 : 0;
            if (evt != 0 || busy != 0) m_idle = 0;
            else if (m_idle < IDLE) m_idle++;
            if (act == 0) begin
                m_valid = 0; m_miss = 0; m_hit = 0; m_ready = 0;
            end else begin
                rp = lat_en ? int'(page_addr) : m_cur;
                if (evt != 0 && m_valid != 0 && m_tag == rp) begin
                    m_hit = HIT; m_ready = 0;
                end else if (evt != 0 && !(m_miss > 0 && m_tag == rp)) begin
                    m_miss = MISS; m_tag = rp; m_valid = 0; m_hit = 0; m_ready = 0;
                end else begin
                    if (m_miss == 1) begin
                        for (int k = 0; k < 4; k++) m_buf[k] = ref_word(m_tag * 4 + k);
                        m_valid = 1; m_data = m_buf[word_sel]; m_ready = 1;
                    end
                    if (m_hit == 1) begin
                        m_data = m_buf[word_sel]; m_ready = 1;
                    end
                    if (m_miss > 0) m_miss--;
                    if (m_hit > 0) m_hit--;
                end
                if (evt != 0) m_lo = int'(word_sel);
                if (evt != 0 && lat_en) m_cur = int'(page_addr);
            end
        end
        #3;
        if (!rst && !done_flag) begin
            chk("rd_ready", int'(rd_ready), m_ready);
            chk("rd_data (R11/R12)", int'(rd_data), oe ? m_data : 0);
            chk("standby (R8)", int'(standby), (m_idle == IDLE) ? 1 : 0);
            chk("wait_o (R10)", int'(wait_o), int'(cfg_word[15]));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // drive one access and measure edges until rd_ready
    task automatic timed(int pg, int sel, bit use_le, int lat, string tag);
        int n;
        @(negedge clk);
        phase = tag;
        lat_en = use_le; word_sel = 2'(sel);
        if (use_le) page_addr = 6'(pg);
        n = 0;
        do begin
            @(negedge clk);
            lat_en = 1'b0;
            n++;
        end while (!rd_ready && n < 60);
        chk("latency", n, lat + 1);
        chk("word", int'(rd_data), ref_word(pg * 4 + sel));
    endtask

    task automatic report;
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        int unsigned seed;
        rst = 1; cfg_word = 16'h0; ce = 0; oe = 0; lat_en = 0; page_addr = 0; word_sel = 0;
        cyc(3);
        rst = 0;
        @(negedge clk);
        phase = "R1 reset state";
        chk("rd_ready", int'(rd_ready), 0);
        chk("standby", int'(standby), 0);
        chk("rd_data", int'(rd_data), 0);

        // R10 / R7: mode bit clear keeps block inactive
        phase = "R10 mode bit";
        cfg_word = 16'h7FFF; ce = 1; oe = 1; lat_en = 1; page_addr = 3;
        @(negedge clk); lat_en = 0;
        cyc(10);
        chk("wait_o", int'(wait_o), 0);
        chk("rd_ready R7", int'(rd_ready), 0);
        cfg_word = 16'h8000;
        @(negedge clk);
        chk("wait_o", int'(wait_o), 1);

        timed(5, 2, 1, MISS, "R3 miss fetch");
        timed(5, 1, 1, HIT,  "R6 relatch same page hit");
        timed(5, 3, 0, HIT,  "R5 ungated select hit");
        timed(5, 0, 0, HIT,  "R4 hit latency");
        phase = "R5 rapid select changes";
        for (int k = 0; k < 8; k++) begin
            word_sel = 2'(k);
            @(negedge clk);
        end
        cyc(5);

        timed(9, 0, 1, MISS, "R6 new page miss");
        timed(9, 3, 1, HIT,  "R2 page word map");

        phase = "R13 restart and join";
        lat_en = 1; page_addr = 12; word_sel = 0;
        @(negedge clk); lat_en = 0;
        cyc(2);
        lat_en = 1; page_addr = 13;
        @(negedge clk); lat_en = 0;
        cyc(1);
        word_sel = 2;
        cyc(10);
        chk("R13 joined word", int'(rd_data), ref_word(13 * 4 + 2));

        phase = "R8 standby entry";
        cyc(IDLE + 3);
        chk("R8 standby", int'(standby), 1);
        chk("R8 data held", int'(rd_data), ref_word(13 * 4 + 2));
        timed(13, 1, 0, HIT, "R9 wake into hit");
        cyc(IDLE + 2);
        phase = "R9 wake";
        word_sel = 3;
        @(negedge clk);
        chk("R9 standby cleared", int'(standby), 0);
        cyc(4);

        phase = "R7 chip disable";
        ce = 0; cyc(2); ce = 1;
        timed(13, 2, 1, MISS, "R7 miss after disable");
        cfg_word = 16'h0; cyc(1); cfg_word = 16'h8000;
        timed(13, 0, 1, MISS, "R7 miss after mode off");

        phase = "R11 output enable";
        oe = 0; cyc(3);
        chk("R11 data low", int'(rd_data), 0);
        chk("R11 ready kept", int'(rd_ready), 1);
        oe = 1; cyc(1);

        for (int p = 0; p < 16; p++) begin
            timed(p * 4 + 1, p % 4, 1, MISS, "R12 array contents");
        end

        phase = "R13 mixed traffic";
        seed = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            seed = seed * 1103515245 + 12345;
            @(negedge clk);
            ce       = (seed[27:24] != 4'h0);
            cfg_word = (seed[31:27] == 5'h1) ? 16'h0 : 16'h8000;
            oe       = (seed[23:21] != 3'h0);
            lat_en   = (seed[20:18] == 3'h0);
            page_addr = {4'h0, seed[17:16]};
            if (seed[15:13] == 3'h0) word_sel = seed[12:11];
        end
        cyc(20);
        report();
    end

endmodule